// File: doc/BRIEF.md
# Dual-Rail Brown-Out Interrupt Controller

This block is the digital half of a supply monitor that watches two rails, one analog and one digital. Each rail has an analog comparator outside the block whose output is high while the rail sits above a chosen threshold. The block brings both comparator outputs into the clock domain and filters them. It keeps an 8-bit control and status register that software reads and writes. It also drives a sticky interrupt flag toward the core, so that software can save state before the supply gives out.

A low rail sets the flag while the monitor is enabled. The flag then stays set until both rails have read good for an unbroken hold-off interval, which is 250 ms at the default clock. Any new dip during that interval starts the count again. Software may set the flag at any time. It may clear the flag only while both rails are good. The two 2-bit threshold codes held in the register are driven to the analog comparators as they are.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset the register reads 8'hDE, irq_o is 0 and both threshold outputs are 2'b11.
- R2: Register bits: [7] filtered digital-rail status, [6] filtered analog-rail status, [5] interrupt flag, [4:3] digital threshold code, [2:1] analog threshold code, [0] enable. A write updates bits 5:0 on the next clock edge. Writes to bits 7 and 6 have no effect.
- R3: While enable is 1, a filtered status of 0 on either rail sets the flag on the next edge. irq_o always equals the flag.
- R4: When the flag is set and both filtered rails are good, the flag clears by itself after HOLD_CYCLES consecutive good cycles, and not earlier.
- R5: If either filtered rail goes low while the hold-off is counting, the count restarts from zero and the flag stays set.
- R6: A software write of 1 to bit 5 sets the flag whatever the rail state. A write of 0 clears it only if both filtered rails are good, and has no effect otherwise.
- R7: Bits [4:3] drive trip_d_o and bits [2:1] drive trip_a_o unchanged. The codes are 00 for the highest threshold, then 01 and 10, down to 11 for the lowest.
- R8: While enable is 0, a low rail does not set the flag.
- R9: Each comparator input passes through a two-flop synchronizer and a filter that accepts a new level only after FILT_LEN consecutive agreeing samples. A dip of fewer than FILT_LEN cycles changes neither the status bits nor the flag. A dip of FILT_LEN cycles or more is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rail_a_ok_i | input | 1 | Analog-rail comparator, 1 = above threshold (asynchronous) |
| rail_d_ok_i | input | 1 | Digital-rail comparator, 1 = above threshold (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Sticky supply interrupt flag |
| trip_a_sel_o | output | 2 | Analog threshold code to comparator |
| trip_d_sel_o | output | 2 | Digital threshold code to comparator |

## Verification
A filter stuck on an old level shows at bits 7 and 6 of the read data. Status bits that lag an accepted dip by more than FILT_LEN+2 cycles show there too. A hold-off counter that does not restart, or that runs for the wrong length, shows as irq_o falling early or late. The bench puts margins of a few cycles around HOLD_CYCLES to catch this. A wrong priority between software writes and rail events shows on irq_o one cycle after the write.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_STAT_D  = 7;
  localparam int BIT_STAT_A  = 6;
  localparam int BIT_FLAG    = 5;
  localparam int BIT_TRIPD_H = 4;
  localparam int BIT_TRIPD_L = 3;
  localparam int BIT_TRIPA_H = 2;
  localparam int BIT_TRIPA_L = 1;
  localparam int BIT_EN      = 0;
  localparam int RAIL_A      = 0;
  localparam int RAIL_D      = 1;
  localparam int NUM_RAILS   = 2;

  typedef struct packed {
    logic [1:0] trip_d;
    logic [1:0] trip_a;
    logic       en;
  } supmon_ctl_t;

  localparam supmon_ctl_t CTL_RESET = '{trip_d: 2'b11, trip_a: 2'b11, en: 1'b0};
endpackage

// File: rtl/supmon_filt.sv
module supmon_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          sync_q1, sync_q2;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // two-flop synchronizer, resets to "rail good"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b1;
      sync_q2 <= 1'b1;
    end else begin
      sync_q1 <= raw_i;
      sync_q2 <= sync_q1;
    end
  end

  // agreement filter next state
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (sync_q2 != lvl_q) begin
      if (cnt_q == LAST) begin
        lvl_d = sync_q2;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/supmon_holdoff.sv
module supmon_holdoff #(
  parameter int HOLD_CYCLES = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  always_comb begin
    done  = run_i && (cnt_q == LAST);
    cnt_d = '0;
    if (run_i && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = done;
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int HOLD_CYCLES = 62_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rail_a_ok_i,
  input  logic       rail_d_ok_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic [1:0] trip_a_sel_o,
  output logic [1:0] trip_d_sel_o
);
  logic [NUM_RAILS-1:0] raw, good;
  logic                 both_good, set_ev, clr_ev, hold_done;
  logic                 flag_q, flag_d;
  supmon_ctl_t          ctl_q, ctl_d;
  logic                 unused_ro_wr;

  assign raw[RAIL_A] = rail_a_ok_i;
  assign raw[RAIL_D] = rail_d_ok_i;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    supmon_filt #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw[g]),
      .level_o (good[g])
    );
  end

  assign both_good = &good;

  supmon_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (flag_q && both_good),
    .done_o (hold_done)
  );

  // control fields next state
  always_comb begin
    ctl_d = ctl_q;
    if (reg_wr_i) begin
      ctl_d.trip_d = reg_wdata_i[BIT_TRIPD_H:BIT_TRIPD_L];
      ctl_d.trip_a = reg_wdata_i[BIT_TRIPA_H:BIT_TRIPA_L];
      ctl_d.en     = reg_wdata_i[BIT_EN];
    end
  end

  // flag next state: setting wins over clearing
  always_comb begin
    set_ev = (ctl_q.en && !both_good) || (reg_wr_i && reg_wdata_i[BIT_FLAG]);
    clr_ev = hold_done || (reg_wr_i && !reg_wdata_i[BIT_FLAG] && both_good);
    flag_d = flag_q;
    if (set_ev)      flag_d = 1'b1;
    else if (clr_ev) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end
  end

  assign unused_ro_wr = ^reg_wdata_i[BIT_STAT_D:BIT_STAT_A];

  assign reg_rdata_o  = {good[RAIL_D], good[RAIL_A], flag_q, ctl_q.trip_d, ctl_q.trip_a, ctl_q.en};
  assign irq_o        = flag_q;
  assign trip_a_sel_o = ctl_q.trip_a;
  assign trip_d_sel_o = ctl_q.trip_d;
endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic [1:0] trip_a_sel_o,
  input logic [1:0] trip_d_sel_o
);
  logic ok_both;
  assign ok_both = reg_rdata_o[7] && reg_rdata_o[6];

  // R3: enabled and a rail low -> flag set next cycle
  a_r3_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[0] && !ok_both) |=> irq_o);

  // R6: flag cannot drop while a rail is low
  a_r6_no_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ok_both) |=> irq_o);

  // R4: flag only falls after a cycle with both rails good
  a_r4_fall_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(ok_both));

  // R7: threshold codes follow the write data
  a_r7_trip_follow: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (trip_a_sel_o == $past(reg_wdata_i[2:1]) &&
                  trip_d_sel_o == $past(reg_wdata_i[4:3])));

  // R8: disabled and no write -> flag does not rise
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !reg_rdata_o[0] && !reg_wr_i) |=> !irq_o);
endmodule

bind supmon_ctrl supmon_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .trip_a_sel_o (trip_a_sel_o),
  .trip_d_sel_o (trip_d_sel_o)
);

// File: tb/test_supmon_ctrl.sv
`timescale 1ns/1ps
module test_supmon_ctrl;
  localparam int FILT = 4;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rail_a = 1'b1, rail_d = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] tra, trd;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;

  supmon_ctrl #(.FILT_LEN(FILT), .HOLD_CYCLES(HOLD)) i_supmon_ctrl (
    .clk(clk), .rst_n(rst_n), .rail_a_ok_i(rail_a), .rail_d_ok_i(rail_d),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .trip_a_sel_o(tra), .trip_d_sel_o(trd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(rdata == 8'hDE, "R1 rdata", rdata, 8'hDE);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(tra == 2'b11 && trd == 2'b11, "R1 trip", {trd, tra}, 4'hF);
  endtask

  task automatic t_regs;
    wr_reg(8'hFF);
    chk(rdata == 8'hFF, "R2 write all ones", rdata, 8'hFF);
    wr_reg(8'h00);
    chk(rdata == 8'hC0, "R2 status bits ignore write", rdata, 8'hC0);
  endtask

  task automatic t_trip;
    wr_reg(8'h12);
    chk(tra == 2'b01 && trd == 2'b10, "R7 trip out", {trd, tra}, 4'h9);
    chk(rdata == 8'hD2, "R7 readback", rdata, 8'hD2);
  endtask

  task automatic t_holdoff;
    wr_reg(8'h01);
    rail_a = 1'b0; cyc(12);
    chk(irq == 1'b1, "R3 low sets irq", irq, 1);
    chk(rdata[6] == 1'b0 && rdata[7] == 1'b1, "R2 analog status low", rdata, 8'h81);
    rail_a = 1'b1;
    cyc(43);
    chk(irq == 1'b1, "R4 not cleared early", irq, 1);
    cyc(7);
    chk(irq == 1'b0, "R4 cleared after hold", irq, 0);
  endtask

  task automatic t_restart;
    rail_d = 1'b0; cyc(10);
    chk(irq == 1'b1, "R3 digital low sets irq", irq, 1);
    rail_d = 1'b1; cyc(30);
    rail_d = 1'b0; cyc(10);
    chk(irq == 1'b1, "R5 irq held over dip", irq, 1);
    rail_d = 1'b1; cyc(30);
    chk(irq == 1'b1, "R5 count restarted", irq, 1);
    cyc(20);
    chk(irq == 1'b0, "R5 cleared after full hold", irq, 0);
  endtask

  task automatic t_sw;
    wr_reg(8'h21);
    chk(irq == 1'b1, "R6 sw set", irq, 1);
    wr_reg(8'h01);
    chk(irq == 1'b0, "R6 sw clear rails good", irq, 0);
    wr_reg(8'h00);
    rail_a = 1'b0; cyc(12);
    chk(irq == 1'b0, "R8 disabled no set", irq, 0);
    wr_reg(8'h20);
    chk(irq == 1'b1, "R6 sw set with rail low", irq, 1);
    wr_reg(8'h00);
    chk(irq == 1'b1, "R6 sw clear blocked", irq, 1);
    rail_a = 1'b1; cyc(60);
    chk(irq == 1'b0, "R4 hold clears while disabled", irq, 0);
  endtask

  task automatic t_glitch;
    wr_reg(8'h01);
    rail_d = 1'b0; cyc(FILT - 1); rail_d = 1'b1; cyc(20);
    chk(irq == 1'b0, "R9 short dip rejected", irq, 0);
    chk(rdata[7] == 1'b1, "R9 status unchanged", rdata[7], 1);
    rail_d = 1'b0; cyc(FILT); rail_d = 1'b1; cyc(3);
    chk(irq == 1'b1, "R9 dip of FILT_LEN accepted", irq, 1);
    cyc(60);
    chk(irq == 1'b0, "R4 clears after accepted dip", irq, 0);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset();
        t_regs();
        t_trip();
        t_holdoff();
        t_restart();
        t_sw();
        t_glitch();
      end
      begin
        cyc(20000);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule